// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block holds the address of a synchronous burst memory port and steps the low two bits of it through a four-beat burst. A start address is taken from the external address bus when the cycle controller qualifies the cycle and at least one of two active-low address strobes is low. After that, each clock edge that sees the advance input low, with both strobes high, moves on to the next beat.

The beat order comes from a static order-select input. With the input high, the order is interleaved: the low bits are the start value XOR a beat count. With the input low, the order is linear: the low bits count up from the start value modulo four. The upper address bits keep the loaded value for the whole burst. After the fourth beat the sequence returns to the start value. It never carries into the upper bits.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset, `addr_out` is all zeros.
- R2: On a rising edge where `load_ok` is 1 and either `strb_a_n` or `strb_b_n` is 0, the start address is captured. From the next cycle `addr_out` equals the sampled `addr_in`.
- R3: A strobe that is low while `load_ok` is 0 loads nothing and advances nothing. `addr_out` holds.
- R4: The burst steps one beat on a rising edge only where `adv_n` is 0 and both strobes are 1.
- R5: `adv_n` has no effect on an edge that loads an address. The next `addr_out` is the loaded start address.
- R6: With `order_il` = 1 (interleaved), beat k (k = 0..3) drives `addr_out[1:0]` = start[1:0] XOR k.
- R7: With `order_il` = 0 (linear), beat k drives `addr_out[1:0]` = (start[1:0] + k) mod 4.
- R8: `addr_out[ADDR_W-1:2]` keeps the loaded upper bits across all advances.
- R9: With `adv_n` = 1 and no load, `addr_out` holds unchanged.
- R10: The fifth and later advances wrap: beat k+4 equals beat k, and the start value returns after four advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_ok | input | 1 | Cycle controller qualifier; a strobe is accepted only when 1 |
| strb_a_n | input | 1 | First address strobe, active low |
| strb_b_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with `ADDR_W` = 6, so the four-bit upper field and the two-bit beat field are both small. For both order settings it sweeps every two-bit start value under two distinct upper patterns. Each burst runs six advances, which covers the whole four-beat sequence and the wrap after it. It also applies loads with advance low, strobes without the qualifier, loads through each strobe alone, and idle holds.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] beat_map(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] idx,
    input logic              interleave
  );
    if (interleave) beat_map = start ^ idx;
    else            beat_map = start + idx;
  endfunction
endpackage

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (load_evt) base_q <= addr_in;
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(base_q)); // R8
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              step_evt,
  output logic [BEAT_W-1:0] idx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (load_evt) idx_q <= '0;
    else if (step_evt) idx_q <= idx_q + BEAT_W'(1);
  end

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> idx_q == '0); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !load_evt) |=> idx_q == BEAT_W'($past(idx_q) + 1)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !load_evt) |=> $stable(idx_q)); // R9
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ok,
  input  logic              strb_a_n,
  input  logic              strb_b_n,
  input  logic              adv_n,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              any_strobe;
  logic              load_evt;
  logic              step_evt;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] idx_q;
  logic [BEAT_W-1:0] beat_lo;

  assign any_strobe = !strb_a_n || !strb_b_n;
  assign load_evt   = load_ok && any_strobe;
  assign step_evt   = !adv_n && strb_a_n && strb_b_n;

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .addr_in  (addr_in),
    .base_q   (base_q)
  );

  burst_beat_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .idx_q    (idx_q)
  );

  assign beat_lo  = beat_map(base_q[BEAT_W-1:0], idx_q, order_il);
  assign addr_out = {base_q[ADDR_W-1:BEAT_W], beat_lo};

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> addr_out == $past(addr_in)); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])); // R8
  AST_UNQUAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ok && any_strobe && $stable(order_il)) |=> $stable(addr_out)); // R3
  initial assert (UP_W >= 1); // R8
endmodule

// File: tb/burst_seq_gen_bench.sv
module burst_seq_gen_bench;
  localparam int AW = 6;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          load_ok = 0, strb_a_n = 1, strb_b_n = 1, adv_n = 1, order_il = 1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_seq_gen #(.ADDR_W(AW)) u_burst_seq_gen (
    .clk(clk), .rst_n(rst_n), .load_ok(load_ok), .strb_a_n(strb_a_n),
    .strb_b_n(strb_b_n), .adv_n(adv_n), .order_il(order_il),
    .addr_in(addr_in), .addr_out(addr_out)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, addr_out, exp);
    end
  endtask

  function automatic logic [AW-1:0] model(input logic [AW-1:0] s, input int k, input bit il);
    int lo;
    if (il) lo = (s % 4) ^ (k % 4);
    else    lo = ((s % 4) + k) % 4;
    return logic'(0) | ((s / 4) * 4 + lo);
  endfunction

  // drive on negedge, let one posedge pass, sample 1 time unit later
  task automatic cyc(input bit q, input bit a, input bit b, input bit adv, input logic [AW-1:0] ai);
    @(negedge clk);
    load_ok = q; strb_a_n = a; strb_b_n = b; adv_n = adv; addr_in = ai;
    @(posedge clk); #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] st;
    repeat (2) @(posedge clk);
    #1 check("R1", '0);
    @(negedge clk); rst_n = 1;

    for (int m = 0; m < 2; m++) begin
      for (int u = 0; u < 2; u++) begin
        for (int s = 0; s < 4; s++) begin
          order_il = m[0];
          st = AW'((u == 0 ? 5 : 10) * 4 + s);
          // load via alternating strobe, adv low on the load edge (R5)
          if (s[0]) cyc(1, 0, 1, 0, st); else cyc(1, 1, 0, 0, st);
          check("R2 R5", st);
          for (int k = 1; k <= 6; k++) begin
            cyc(0, 1, 1, 0, ~st);
            if (k >= 4) check("R10", model(st, k, m[0]));
            else if (m[0]) check("R6 R8", model(st, k, 1));
            else check("R7 R8", model(st, k, 0));
          end
          cyc(0, 1, 1, 1, ~st);
          check("R9", model(st, 6, m[0]));
          cyc(0, 0, 0, 0, ~st);
          check("R3", model(st, 6, m[0]));
          cyc(0, 0, 1, 0, ~st);
          check("R4", model(st, 6, m[0]));
          cyc(0, 1, 1, 0, ~st);
          check("R4", model(st, 7, m[0]));
        end
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule